// File: doc/BRIEF.md
# Slot Enumeration and Control Register Window

This block gives one expansion-slot device its enumeration and control window on a 24-bit address, 32-bit data system bus. The slot number comes from a geographic `slot_id` input. The window is claimed only when the upper address byte is 0x11 and address bits 15:8 equal that slot number, which allows 32 slots. Inside the 256-byte window, software reads a presence marker and the device identity: class, subclass, device number and a 32-bit builder code. It also posts commands and exchanges five 16-bit parameter words with the device core.

Each access is a single-cycle request. It carries a byte address, a size code and write data that is aligned to the least significant lane. Byte `k` of a transfer maps to window offset `base + k`, so the layout is little-endian and unaligned accesses are allowed. A read returns its data one cycle after the request. A write that covers either byte of the command word raises a one-cycle strobe toward the device core and carries the value written. The device core can overwrite any parameter word to report status.

A small output state machine decides what the outputs do in each cycle. It has three states: `ST_IDLE` (no output), `ST_READ_OUT` (read data valid) and `ST_CMD_OUT` (command strobe). In every cycle the next state is chosen from the current request. An accepted read moves the machine to `ST_READ_OUT`. An accepted write that touches the command word moves it to `ST_CMD_OUT`. Any other case moves it to `ST_IDLE`. These three transitions apply from every state, so back-to-back requests are accepted in every cycle.

Top module: `slot_regwin`

## Requirements
- R1: A request is accepted only when `req_addr[23:16]` is 0x11 and `req_addr[15:8]` equals `slot_id` zero-extended to 8 bits. Any other address gives no read response, no command strobe and no change to stored state.
- R2: `req_size` selects the transfer width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. An accepted read raises `rsp_valid` for exactly the next cycle. Byte `k` of `rsp_rdata` holds window offset `req_addr[7:0]+k`. Lanes beyond the transfer width read 0. `rsp_valid` and `cmd_stb` are never high together.
- R3: Offset 0 reads 0xFF while `dev_present` is 1 and reads 0x00 while it is 0.
- R4: Offsets 1, 2 and 3 read the class, subclass and device number parameters. Offsets 4 to 7 read the 32-bit builder code, least significant byte at offset 4.
- R5: Offsets 8 and 9 read as 0. Writes to offsets 0 to 7 change nothing.
- R6: An accepted write that covers offset 8 or 9 raises `cmd_stb` for exactly the next cycle. `cmd_data[7:0]` takes the byte written to offset 8 and `cmd_data[15:8]` takes the byte written to offset 9. A byte that was not written is 0.
- R7: Offsets 10 to 19 hold five read/write 16-bit words, A at 10, B at 12, C at 14, D at 16 and E at 18, each stored low byte first. They can be written per byte and all reset to 0.
- R8: When `core_wr_en` is high and `core_wr_sel` is 0 to 4, the selected word (0 for A through 4 for E) takes `core_wr_data` at the clock edge. The core write takes priority over a bus write to the same byte in the same cycle. Select values above 4 change nothing.
- R9: Offsets 20 to 255 read as 0 and ignore writes. Transfer lanes whose offset passes 255 read 0 and write nothing.
- R10: While `rst_n` is low, `rsp_valid` and `cmd_stb` are held low and the parameter words are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_id | input | 5 | Slot number this window decodes |
| dev_present | input | 1 | Device fitted in the slot |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer width code |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 32 | Write data, lane 0 at the addressed byte |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, lane 0 from the addressed byte |
| cmd_stb | output | 1 | One-cycle command strobe to the core |
| cmd_data | output | 16 | Command value written |
| core_wr_en | input | 1 | Core status write enable |
| core_wr_sel | input | 3 | Parameter word index (0 = A … 4 = E) |
| core_wr_data | input | 16 | Core status value |

## Verification
Read data and the command strobe both appear in the cycle after the edge that accepts the request. Each has one register between the request and the output. A core or bus write to a parameter word is visible to a read issued in the following cycle. The driver applies each request half a cycle before its edge. It queues the expected result and then waits exactly one cycle. A monitor samples the outputs on every falling edge and compares them with the head of the queue. Any output with nothing queued is reported as a failure. Missing outputs show up as entries still left in the queue. For cases where nothing should happen, the outputs are sampled in the cycle the response would have appeared, and stored state is read back later.

// File: rtl/slot_regwin_pkg.sv
package slot_regwin_pkg;

    localparam int unsigned LANES       = 4;
    localparam int unsigned OFS_W       = 8;
    localparam int unsigned PARAM_REGS  = 5;
    localparam int unsigned PARAM_BYTES = PARAM_REGS * 2;

    localparam logic [OFS_W-1:0] OFS_PRESENT = 8'd0;
    localparam logic [OFS_W-1:0] OFS_CLASS   = 8'd1;
    localparam logic [OFS_W-1:0] OFS_SUBCL   = 8'd2;
    localparam logic [OFS_W-1:0] OFS_IDENT   = 8'd3;
    localparam logic [OFS_W-1:0] OFS_BUILDER = 8'd4;
    localparam logic [OFS_W-1:0] OFS_CMD     = 8'd8;
    localparam logic [OFS_W-1:0] OFS_PARAM   = 8'd10;
    localparam logic [OFS_W-1:0] OFS_END     = OFS_PARAM + 8'(PARAM_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ_OUT = 2'd1,
        ST_CMD_OUT  = 2'd2
    } win_state_e;

    typedef struct packed {
        logic             on;
        logic [OFS_W-1:0] ofs;
    } lane_t;

    function automatic logic [2:0] lane_count(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/slot_addr_decode.sv
module slot_addr_decode
    import slot_regwin_pkg::*;
#(
    parameter int unsigned          ADDR_W     = 24,
    parameter int unsigned          SLOT_W     = 5,
    parameter logic [ADDR_W-17:0]   REGION_TAG = 8'h11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic [1:0]        size,
    output logic              hit,
    output lane_t             lanes [LANES]
);

    localparam int unsigned SUM_W = OFS_W + 1;

    assign hit = (addr[ADDR_W-1:16] == REGION_TAG) &&
                 (addr[15:8] == 8'(slot_id));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SUM_W-1:0] sum;
        assign sum          = {1'b0, addr[OFS_W-1:0]} + SUM_W'(i);
        assign lanes[i].on  = hit && (3'(i) < lane_count(size)) && !sum[OFS_W];
        assign lanes[i].ofs = sum[OFS_W-1:0];
    end

endmodule

// File: rtl/slot_param_bank.sv
module slot_param_bank
    import slot_regwin_pkg::*;
#(
    parameter int unsigned SEL_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_go,
    input  lane_t                    lanes [LANES],
    input  logic [8*LANES-1:0]       wdata,
    input  logic                     core_en,
    input  logic [SEL_W-1:0]         core_sel,
    input  logic [15:0]              core_data,
    output logic [8*PARAM_BYTES-1:0] bytes_q
);

    for (genvar j = 0; j < PARAM_BYTES; j++) begin : g_cell
        logic       bus_hit;
        logic [7:0] bus_byte;
        logic       core_hit;
        logic [7:0] cell_q;

        always_comb begin
            bus_hit  = 1'b0;
            bus_byte = '0;
            for (int i = 0; i < LANES; i++) begin
                if (wr_go && lanes[i].on && lanes[i].ofs == OFS_PARAM + 8'(j)) begin
                    bus_hit  = 1'b1;
                    bus_byte = wdata[8*i +: 8];
                end
            end
        end

        assign core_hit = core_en && (core_sel == SEL_W'(j / 2));

        always_ff @(posedge clk) begin
            if (!rst_n)        cell_q <= '0;
            else if (core_hit) cell_q <= core_data[8*(j%2) +: 8];
            else if (bus_hit)  cell_q <= bus_byte;
        end

        assign bytes_q[8*j +: 8] = cell_q;
    end

endmodule

// File: rtl/slot_regwin.sv
module slot_regwin
    import slot_regwin_pkg::*;
#(
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned SLOT_W      = 5,
    parameter int unsigned SEL_W       = 3,
    parameter logic [7:0]  DEV_CLASS   = 8'h02,
    parameter logic [7:0]  DEV_SUBCL   = 8'h01,
    parameter logic [7:0]  DEV_IDENT   = 8'h3C,
    parameter logic [31:0] DEV_BUILDER = 32'h5A17C0DE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SLOT_W-1:0]   slot_id,
    input  logic                dev_present,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [8*LANES-1:0]  req_wdata,
    output logic                rsp_valid,
    output logic [8*LANES-1:0]  rsp_rdata,
    output logic                cmd_stb,
    output logic [15:0]         cmd_data,
    input  logic                core_wr_en,
    input  logic [SEL_W-1:0]    core_wr_sel,
    input  logic [15:0]         core_wr_data
);

    localparam int unsigned DATA_W = 8 * LANES;

    logic                     hit;
    lane_t                    lanes [LANES];
    logic [8*PARAM_BYTES-1:0] params_q;
    logic                     rd_go, wr_go;
    logic                     cmd_touch;
    logic [15:0]              cmd_next, cmd_q;
    logic [DATA_W-1:0]        rd_next, rd_q;
    win_state_e               state_q, state_nx;

    slot_addr_decode #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W)
    ) decode_i (
        .addr    (req_addr),
        .slot_id (slot_id),
        .size    (req_size),
        .hit     (hit),
        .lanes   (lanes)
    );

    assign rd_go = req_valid && hit && !req_write;
    assign wr_go = req_valid && hit &&  req_write;

    slot_param_bank #(
        .SEL_W (SEL_W)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .lanes     (lanes),
        .wdata     (req_wdata),
        .core_en   (core_wr_en),
        .core_sel  (core_wr_sel),
        .core_data (core_wr_data),
        .bytes_q   (params_q)
    );

    // Command word capture from the write lanes
    always_comb begin
        cmd_touch = 1'b0;
        cmd_next  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (wr_go && lanes[i].on) begin
                if (lanes[i].ofs == OFS_CMD) begin
                    cmd_touch     = 1'b1;
                    cmd_next[7:0] = req_wdata[8*i +: 8];
                end
                if (lanes[i].ofs == OFS_CMD + 8'd1) begin
                    cmd_touch      = 1'b1;
                    cmd_next[15:8] = req_wdata[8*i +: 8];
                end
            end
        end
    end

    // Read byte selection per lane
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [OFS_W-1:0]         o;
            logic [OFS_W-1:0]         pidx;
            logic [8*PARAM_BYTES-1:0] pshift;
            logic [31:0]              bshift;
            logic [7:0]               val;
            o      = lanes[i].ofs;
            pidx   = o - OFS_PARAM;
            pshift = params_q >> {pidx, 3'b000};
            bshift = DEV_BUILDER >> {o[1:0], 3'b000};
            val    = '0;
            if (o == OFS_PRESENT)                        val = dev_present ? 8'hFF : 8'h00;
            else if (o == OFS_CLASS)                     val = DEV_CLASS;
            else if (o == OFS_SUBCL)                     val = DEV_SUBCL;
            else if (o == OFS_IDENT)                     val = DEV_IDENT;
            else if (o >= OFS_BUILDER && o < OFS_CMD)    val = bshift[7:0];
            else if (o >= OFS_PARAM && o < OFS_END)      val = pshift[7:0];
            if (lanes[i].on) rd_next[8*i +: 8] = val;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next-state selection (same from every state)
    always_comb begin
        if (rd_go)          state_nx = ST_READ_OUT;
        else if (cmd_touch) state_nx = ST_CMD_OUT;
        else                state_nx = ST_IDLE;
    end

    // Output data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            cmd_q <= '0;
        end else begin
            if (rd_go)     rd_q  <= rd_next;
            if (cmd_touch) cmd_q <= cmd_next;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rsp_valid = 1'b0;
        cmd_stb   = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_READ_OUT: rsp_valid = 1'b1;
            ST_CMD_OUT:  cmd_stb   = 1'b1;
            default:     ;
        endcase
    end

    assign rsp_rdata = rd_q;
    assign cmd_data  = cmd_q;

endmodule

// File: rtl/slot_regwin_chk.sv
module slot_regwin_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  slot_id,
    input logic        dev_present,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic [23:0] req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        cmd_stb
);

    // R1
    rsp_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_addr[23:16] == 8'h11 && req_addr[15:8] == {3'b000, slot_id}));

    // R2
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // R2
    byte_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_size == 2'd0)) |-> rsp_rdata[31:8] == 24'h0);

    // R2
    outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, cmd_stb}));

    // R3
    present_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_addr[7:0] == 8'h00)) |->
        rsp_rdata[7:0] == ($past(dev_present) ? 8'hFF : 8'h00));

    // R5
    cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_addr[7:0] == 8'd8 && req_size == 2'd1)) |-> rsp_rdata[15:0] == 16'h0);

    // R6
    cmd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(req_valid && req_write));

    // R6
    cmd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> (!cmd_stb || $past(req_valid && req_write)));

endmodule

bind slot_regwin slot_regwin_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_id     (slot_id),
    .dev_present (dev_present),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .cmd_stb     (cmd_stb)
);

// File: tb/slot_regwin_tb.sv
module slot_regwin_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  slot_id = 5'd5;
    logic        dev_present = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        cmd_stb;
    logic [15:0] cmd_data;
    logic        core_wr_en = 1'b0;
    logic [2:0]  core_wr_sel = '0;
    logic [15:0] core_wr_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_regwin dut_i (
        .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .dev_present(dev_present),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cmd_stb(cmd_stb), .cmd_data(cmd_data),
        .core_wr_en(core_wr_en), .core_wr_sel(core_wr_sel), .core_wr_data(core_wr_data)
    );

    typedef struct {
        bit          is_cmd;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    task automatic tally(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor: compares produced outputs against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && (rsp_valid || cmd_stb)) begin
            if (sb.size() == 0) begin
                tally(1'b0, "R1/R6 unexpected output", rsp_valid ? rsp_rdata : {16'h0, cmd_data}, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_cmd)
                    tally(cmd_stb && !rsp_valid && cmd_data == e.val[15:0], e.tag, {16'h0, cmd_data}, e.val);
                else
                    tally(rsp_valid && !cmd_stb && rsp_rdata == e.val, e.tag, rsp_rdata, e.val);
            end
        end
    end

    function automatic logic [23:0] own(input logic [7:0] o);
        return {8'h11, 8'h05, o};
    endfunction

    task automatic issue(input bit wr, input logic [1:0] sz, input logic [23:0] a, input logic [31:0] wd);
        req_valid = 1'b1;
        req_write = wr;
        req_size  = sz;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] o, input logic [1:0] sz, input logic [31:0] expv, input string tag);
        sb.push_back('{is_cmd: 1'b0, val: expv, tag: tag});
        issue(1'b0, sz, own(o), 32'h0);
    endtask

    task automatic wr(input logic [7:0] o, input logic [1:0] sz, input logic [31:0] wd);
        issue(1'b1, sz, own(o), wd);
    endtask

    task automatic wrc(input logic [7:0] o, input logic [1:0] sz, input logic [31:0] wd,
                       input logic [15:0] expc, input string tag);
        sb.push_back('{is_cmd: 1'b1, val: {16'h0, expc}, tag: tag});
        issue(1'b1, sz, own(o), wd);
    endtask

    task automatic quiet_now(input string tag);
        tally(!rsp_valid && !cmd_stb, tag, {30'h0, rsp_valid, cmd_stb}, 32'h0);
    endtask

    task automatic core(input logic [2:0] sel, input logic [15:0] d);
        core_wr_en   = 1'b1;
        core_wr_sel  = sel;
        core_wr_data = d;
        @(negedge clk);
        core_wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        quiet_now("R10 outputs low out of reset");
        rd(8'd12, 2'd2, 32'h0, "R10 parameter words cleared");

        rd(8'd0, 2'd0, 32'h0000_00FF, "R3 presence byte");
        rd(8'd1, 2'd0, 32'h0000_0002, "R2 R4 class byte, upper lanes zero");
        rd(8'd0, 2'd2, 32'h3C01_02FF, "R4 identity dword");
        rd(8'd4, 2'd2, 32'h5A17_C0DE, "R4 builder code");
        rd(8'd5, 2'd1, 32'h0000_17C0, "R2 unaligned word");
        rd(8'd8, 2'd1, 32'h0, "R5 command reads zero");

        wr(8'd0, 2'd2, 32'hFFFF_FFFF);
        wr(8'd4, 2'd3, 32'h0);
        rd(8'd0, 2'd2, 32'h3C01_02FF, "R5 identity unchanged by write");
        rd(8'd4, 2'd2, 32'h5A17_C0DE, "R5 builder unchanged by write");

        wrc(8'd8, 2'd1, 32'h0000_BEEF, 16'hBEEF, "R6 word command");
        @(negedge clk);
        quiet_now("R6 strobe lasts one cycle");
        wrc(8'd9, 2'd0, 32'h0000_007A, 16'h7A00, "R6 high byte only");

        wr(8'd10, 2'd2, 32'h4433_2211);
        rd(8'd10, 2'd2, 32'h4433_2211, "R7 dword A/B");
        rd(8'd12, 2'd0, 32'h0000_0033, "R7 byte of B");
        wr(8'd18, 2'd1, 32'h0000_CAFE);
        rd(8'd18, 2'd1, 32'h0000_CAFE, "R7 word E");
        rd(8'd16, 2'd2, 32'hCAFE_0000, "R7 D and E");
        wrc(8'd8, 2'd2, 32'h9988_7766, 16'h7766, "R6 dword covering command");
        rd(8'd10, 2'd1, 32'h0000_9988, "R7 A from straddling write");

        core(3'd2, 16'h1234);
        rd(8'd14, 2'd1, 32'h0000_1234, "R8 core writes C");
        core(3'd5, 16'hFFFF);
        rd(8'd12, 2'd2, 32'h1234_4433, "R8 select 5 ignored (B,C)");
        rd(8'd16, 2'd2, 32'hCAFE_0000, "R8 select 5 ignored (D,E)");

        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0;
        req_addr = own(8'd10); req_wdata = 32'h0000_00AA;
        core_wr_en = 1'b1; core_wr_sel = 3'd0; core_wr_data = 16'h5566;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; core_wr_en = 1'b0;
        rd(8'd10, 2'd1, 32'h0000_5566, "R8 core beats bus");

        rd(8'd20, 2'd2, 32'h0, "R9 reserved reads zero");
        wr(8'd40, 2'd2, 32'hFFFF_FFFF);
        rd(8'd40, 2'd2, 32'h0, "R9 reserved ignores write");
        rd(8'd255, 2'd2, 32'h0, "R9 top of window");

        issue(1'b0, 2'd2, 24'h110600, 32'h0);
        quiet_now("R1 other slot read");
        issue(1'b1, 2'd1, 24'h11060A, 32'h0000_DEAD);
        quiet_now("R1 other slot write");
        issue(1'b1, 2'd1, 24'h110608, 32'h0000_1111);
        quiet_now("R1 other slot command");
        issue(1'b0, 2'd0, 24'h120500, 32'h0);
        quiet_now("R1 other region");
        rd(8'd10, 2'd1, 32'h0000_5566, "R1 miss left A intact");

        dev_present = 1'b0;
        rd(8'd0, 2'd0, 32'h0, "R3 empty slot marker");

        @(negedge clk);
        @(negedge clk);
        tally(sb.size() == 0, "R2 every expected output seen", 32'(sb.size()), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1;
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule